// File: doc/BRIEF.md
# Approximate Compressor-Tree 8x8 Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Each partial-product row is the AND of one operand with one bit of the other. The eight rows pass through two stages of 4:2 compressors and then a carry-resolving adder. Every compressor column holds one of three cells: an exact one or one of two cheaper approximate ones. The approximate cells take both of their carry outputs straight from single inputs. The second approximate cell also flips its sum bit in some input patterns to lower its error.

Three elaboration parameters pick the cell variant, how many low-order first-stage columns use it, and whether the second stage uses it too. Together they give the exact multiplier and six approximate configurations, meant for error-tolerant filtering datapaths. A registered output stage is included by default.

Top module: `apx_mul_top`

## Requirements
- R1: With VARIANT = 0 the product p equals a*b for all 65,536 operand pairs.
- R2: Row i equals (a AND b[i]) shifted left by i. Rows 0..3 feed compressor inputs x1..x4 of one first-stage chain, and rows 4..7 feed a second chain. Each chain spans 16 weight columns. Column k takes its Cin from the Cout of column k-1, column 0 takes Cin = 0, the Carry of column k has weight k+1, and the top column yields only its Sum. The second stage takes x1 = sum0, x2 = carry0, x3 = sum1 and x4 = carry1. p = S + C mod 2^16.
- R3: The exact cell is two full adders. One adds x1, x2 and Cin and gives Cout. The other adds x3, x4 and the first sum and gives Sum and Carry.
- R4: Variant 1 sets Cout = x3 and Carry = x4, with Sum equal to the XOR of all five inputs. Its arithmetic error per cell is at most 2.
- R5: Variant 2 keeps Cout = x3 and Carry = x4. Its Sum is the five-input XOR inverted when any of these holds: Cin·x4'·x3'·(x1⊕x2); x4'·x2·x1·(Cin XNOR x3); Cin'·x2'·x1'·(x3⊕x4); x4·x3·x2'·(Cin⊕x1); x4·x2·(Cin·x3'·x1 + Cin'·x3·x1'). When all five inputs are equal it is exact.
- R6: A first-stage column k uses the approximate cell when k < APPROX_COLS. The whole second stage is approximate when APPROX_STAGE2 = 1. VARIANT 1 or 2 picks the cell. Elaboration stops when VARIANT > 2, when APPROX_COLS > 16, or when VARIANT = 0 is combined with any approximate setting.
- R7: If either operand is zero, p is zero in every configuration.
- R8: If b equals 1, p equals a in every configuration.
- R9: While rst is high, p clears at the next rising edge. Otherwise p shows the result for the operands sampled at the previous edge, and it holds while the operands are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| p | output | 16 | Product, registered one cycle after the operands |

## Verification
The tree has no state other than the output register. A wrong cell equation or a misrouted carry therefore shows up in the same cycle's result, at p one edge later, but only for operand pairs that drive the faulty column to a sensitive input pattern. That is why every configuration is swept over the full operand space against a bit-accurate model, and the exact build against the true product. A faulty output register shows up as a non-zero value after reset or as a one-cycle skew between operands and results.

// File: rtl/apx_mul_pkg.sv
`timescale 1ns/1ps
package apx_mul_pkg;

    localparam int MUL_OP_W   = 8;
    localparam int MUL_PROD_W = 2 * MUL_OP_W;
    localparam int MUL_GROUP  = 4;

    typedef enum logic [1:0] {
        CELL_EXACT = 2'd0,
        CELL_APX1  = 2'd1,
        CELL_APX2  = 2'd2
    } cell_kind_e;

    typedef struct packed {
        logic cin;
        logic x4;
        logic x3;
        logic x2;
        logic x1;
    } cmp_in_t;

    typedef struct packed {
        logic sum;
        logic carry;
        logic cout;
    } cmp_out_t;

    typedef struct packed {
        logic [MUL_PROD_W-1:0] sv;
        logic [MUL_PROD_W-1:0] cv;
    } rpair_t;

    function automatic cell_kind_e kind_of(input int unsigned v);
        case (v)
            1:       return CELL_APX1;
            2:       return CELL_APX2;
            default: return CELL_EXACT;
        endcase
    endfunction

    function automatic logic apx2_fix(input cmp_in_t i);
        logic t1, t2, t3, t4, t5;
        t1 = i.cin & ~i.x4 & ~i.x3 & (i.x1 ^ i.x2);
        t2 = ~i.x4 & i.x2 & i.x1 & ~(i.cin ^ i.x3);
        t3 = ~i.cin & ~i.x2 & ~i.x1 & (i.x3 ^ i.x4);
        t4 = i.x4 & i.x3 & ~i.x2 & (i.cin ^ i.x1);
        t5 = i.x4 & i.x2 & ((i.cin & ~i.x3 & i.x1) | (~i.cin & i.x3 & ~i.x1));
        return t1 | t2 | t3 | t4 | t5;
    endfunction

    function automatic logic cmp_sum(input cell_kind_e k, input cmp_in_t i);
        if (k == CELL_APX2)
            return (^i) ^ apx2_fix(i);
        return ^i;
    endfunction

endpackage

// File: rtl/apx_cmp42.sv
`timescale 1ns/1ps
module apx_cmp42
    import apx_mul_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_EXACT
) (
    input  cmp_in_t  x,
    output cmp_out_t y
);

    generate
        if (KIND == CELL_EXACT) begin : g_exact
            logic t;
            assign t      = x.x1 ^ x.x2 ^ x.cin;
            assign y.cout = (x.x1 & x.x2) | (x.cin & (x.x1 ^ x.x2));
            assign y.sum  = t ^ x.x3 ^ x.x4;
            assign y.carry = (x.x3 & x.x4) | (t & (x.x3 ^ x.x4));
        end else if (KIND == CELL_APX1) begin : g_apx1
            assign y.cout  = x.x3;
            assign y.carry = x.x4;
            assign y.sum   = ^x;
        end else begin : g_apx2
            assign y.cout  = x.x3;
            assign y.carry = x.x4;
            assign y.sum   = (^x) ^ apx2_fix(x);
        end
    endgenerate

endmodule

// File: rtl/apx_cmp_row.sv
`timescale 1ns/1ps
module apx_cmp_row
    import apx_mul_pkg::*;
#(
    parameter int         W        = 16,
    parameter int         APX_COLS = 0,
    parameter cell_kind_e APX_KIND = CELL_EXACT
) (
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    input  logic [W-1:0] x4,
    output logic [W-1:0] s,
    output logic [W-1:0] cv
);

    logic [W-1:0] chain;

    assign chain[0] = 1'b0;
    assign cv[0]    = 1'b0;

    generate
        for (genvar k = 0; k < W; k++) begin : g_col
            localparam cell_kind_e KK = (k < APX_COLS) ? APX_KIND : CELL_EXACT;
            cmp_in_t ci;
            assign ci = '{cin: chain[k], x4: x4[k], x3: x3[k], x2: x2[k], x1: x1[k]};
            if (k == W - 1) begin : g_top
                assign s[k] = cmp_sum(KK, ci);
            end else begin : g_mid
                cmp_out_t co;
                apx_cmp42 #(.KIND(KK)) u_cell (
                    .x (ci),
                    .y (co)
                );
                assign s[k]       = co.sum;
                assign cv[k+1]    = co.carry;
                assign chain[k+1] = co.cout;
            end
        end
    endgenerate

endmodule

// File: rtl/apx_cpa.sv
`timescale 1ns/1ps
module apx_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);

    logic [W-1:0] cy;

    assign cy[0] = 1'b0;

    generate
        for (genvar k = 0; k < W; k++) begin : g_bit
            assign z[k] = x[k] ^ y[k] ^ cy[k];
            if (k < W - 1) begin : g_carry
                assign cy[k+1] = (x[k] & y[k]) | (cy[k] & (x[k] ^ y[k]));
            end
        end
    endgenerate

endmodule

// File: rtl/apx_mul_top.sv
`timescale 1ns/1ps
module apx_mul_top
    import apx_mul_pkg::*;
#(
    parameter int          OP_W          = MUL_OP_W,
    parameter int unsigned VARIANT       = 0,
    parameter int          APPROX_COLS   = 0,
    parameter bit          APPROX_STAGE2 = 1'b0,
    parameter bit          REG_OUT       = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OP_W-1:0]      a,
    input  logic [OP_W-1:0]      b,
    output logic [2*OP_W-1:0]    p
);

    localparam int         PROD_W   = 2 * OP_W;
    localparam int         N_GRP    = OP_W / MUL_GROUP;
    localparam cell_kind_e APX_KIND = kind_of(VARIANT);
    localparam int         ST2_COLS = APPROX_STAGE2 ? PROD_W : 0;

    generate
        if (OP_W != MUL_OP_W) begin : g_bad_width
            $error("apx_mul_top: operand width must be %0d", MUL_OP_W);
        end
        if (VARIANT > 2) begin : g_bad_variant
            $error("apx_mul_top: VARIANT must be 0, 1 or 2");
        end
        if (APPROX_COLS < 0 || APPROX_COLS > PROD_W) begin : g_bad_cols
            $error("apx_mul_top: APPROX_COLS out of range");
        end
        if (VARIANT == 0 && (APPROX_COLS != 0 || APPROX_STAGE2)) begin : g_bad_mix
            $error("apx_mul_top: exact build cannot request approximate columns");
        end
    endgenerate

    logic [PROD_W-1:0] pp [OP_W];
    rpair_t            st1 [N_GRP];
    rpair_t            st2;
    logic [PROD_W-1:0] prod;

    generate
        for (genvar i = 0; i < OP_W; i++) begin : g_pp
            assign pp[i] = {{OP_W{1'b0}}, a & {OP_W{b[i]}}} << i;
        end

        for (genvar g = 0; g < N_GRP; g++) begin : g_st1
            apx_cmp_row #(
                .W        (PROD_W),
                .APX_COLS (APPROX_COLS),
                .APX_KIND (APX_KIND)
            ) u_row (
                .x1 (pp[MUL_GROUP*g + 0]),
                .x2 (pp[MUL_GROUP*g + 1]),
                .x3 (pp[MUL_GROUP*g + 2]),
                .x4 (pp[MUL_GROUP*g + 3]),
                .s  (st1[g].sv),
                .cv (st1[g].cv)
            );
        end
    endgenerate

    apx_cmp_row #(
        .W        (PROD_W),
        .APX_COLS (ST2_COLS),
        .APX_KIND (APX_KIND)
    ) u_st2 (
        .x1 (st1[0].sv),
        .x2 (st1[0].cv),
        .x3 (st1[1].sv),
        .x4 (st1[1].cv),
        .s  (st2.sv),
        .cv (st2.cv)
    );

    apx_cpa #(.W(PROD_W)) u_cpa (
        .x (st2.sv),
        .y (st2.cv),
        .z (prod)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    p <= '0;
                else
                    p <= prod;
            end
        end else begin : g_comb
            assign p = prod;
        end
    endgenerate

endmodule

// File: rtl/apx_mul_chk.sv
`timescale 1ns/1ps
module apx_mul_chk #(
    parameter int unsigned VARIANT = 0,
    parameter bit          REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  a,
    input logic [7:0]  b,
    input logic [15:0] p
);

    generate
        if (REG_OUT) begin : g_seq
            if (VARIANT == 0) begin : g_exact
                // R1
                a_r1_exact_product: assert property (@(posedge clk) disable iff (rst)
                    !rst |=> p == ($past(a) * $past(b)));
            end

            // R7
            a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
                (a == 8'd0 || b == 8'd0) |=> p == 16'd0);

            // R8
            a_r8_unit_multiplier: assert property (@(posedge clk) disable iff (rst)
                (b == 8'd1) |=> p == {8'd0, $past(a)});

            // R9
            a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $stable(a) && $stable(b)) |=> $stable(p));
        end
    endgenerate

endmodule

module apx_cmp42_chk
    import apx_mul_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_EXACT
) (
    input cmp_in_t  x,
    input cmp_out_t y
);

    int in_val;
    int out_val;

    always_comb begin
        in_val  = int'(x.x1) + int'(x.x2) + int'(x.x3) + int'(x.x4) + int'(x.cin);
        out_val = int'(y.sum) + 2 * (int'(y.carry) + int'(y.cout));
        if (!$isunknown({x, y})) begin
            if (KIND == CELL_EXACT) begin
                // R3
                a_r3_exact_cell_value: assert (in_val == out_val);
            end else if (KIND == CELL_APX1) begin
                // R4
                a_r4_apx1_error_bound: assert (out_val - in_val <= 2 && in_val - out_val <= 2);
            end else begin
                // R5
                a_r5_apx2_uniform_exact: assert (!(x == '0 || x == '1) || in_val == out_val);
            end
        end
    end

endmodule

bind apx_mul_top apx_mul_chk #(
    .VARIANT (VARIANT),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .p   (p)
);

bind apx_cmp42 apx_cmp42_chk #(
    .KIND (KIND)
) u_cchk (
    .x (x),
    .y (y)
);

// File: tb/tb_apx_mul_top.sv
`timescale 1ns/1ps
module tb_apx_mul_top;

    localparam int NCFG = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a_drv = '0;
    logic [7:0]  b_drv = '0;
    logic [15:0] p_dut;
    logic [15:0] p_apx [6];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  started = 1'b0;
    bit  done = 1'b0;
    int  err_cnt [NCFG];
    longint err_sum [NCFG];

    typedef struct packed {
        logic [7:0]             a;
        logic [7:0]             b;
        logic [NCFG-1:0][15:0]  exp;
    } item_t;

    item_t q [$];

    always #5 clk = ~clk;

    function automatic int cfg_var(input int i);
        return (i < 3) ? 1 : 2;
    endfunction
    function automatic int cfg_cols(input int i);
        return ((i % 3) == 2) ? 6 : 16;
    endfunction
    function automatic bit cfg_st2(input int i);
        return (i % 3) == 0;
    endfunction

    apx_mul_top #(
        .VARIANT (0)
    ) dut (
        .clk (clk),
        .rst (rst),
        .a   (a_drv),
        .b   (b_drv),
        .p   (p_dut)
    );

    for (genvar i = 0; i < 6; i++) begin : g_apx
        apx_mul_top #(
            .VARIANT       (cfg_var(i)),
            .APPROX_COLS   (cfg_cols(i)),
            .APPROX_STAGE2 (cfg_st2(i))
        ) u_apx (
            .clk (clk),
            .rst (rst),
            .a   (a_drv),
            .b   (b_drv),
            .p   (p_apx[i])
        );
    end

    // Reference cell, written from the arithmetic of R3, R4 and R5.
    function automatic void ref_cell(input int kind, input bit x1, x2, x3, x4, ci,
                                     output bit s, output bit c, output bit co);
        int v1, v2;
        bit par, fix;
        par = x1 ^ x2 ^ x3 ^ x4 ^ ci;
        if (kind == 0) begin
            v1 = int'(x1) + int'(x2) + int'(ci);
            co = (v1 >= 2);
            v2 = int'(x3) + int'(x4) + (v1 % 2);
            s  = v2[0];
            c  = (v2 >= 2);
        end else begin
            co = x3;
            c  = x4;
            fix = 1'b0;
            if (kind == 2) begin
                if (ci && !x4 && !x3 && (x1 != x2)) fix = 1'b1;
                if (!x4 && x2 && x1 && (ci == x3)) fix = 1'b1;
                if (!ci && !x2 && !x1 && (x3 != x4)) fix = 1'b1;
                if (x4 && x3 && !x2 && (ci != x1)) fix = 1'b1;
                if (x4 && x2 && ((ci && !x3 && x1) || (!ci && x3 && !x1))) fix = 1'b1;
            end
            s = par ^ fix;
        end
    endfunction

    // Reference chain of 16 columns (R2, R6).
    function automatic void ref_row(input int kind, input int ncols,
                                    input bit [15:0] x1, x2, x3, x4,
                                    output bit [15:0] s, output bit [15:0] cv);
        bit ci, sb, cb, cob;
        ci = 1'b0;
        s  = '0;
        cv = '0;
        for (int k = 0; k < 16; k++) begin
            ref_cell((k < ncols) ? kind : 0, x1[k], x2[k], x3[k], x4[k], ci, sb, cb, cob);
            s[k] = sb;
            if (k < 15) cv[k+1] = cb;
            ci = cob;
        end
    endfunction

    function automatic bit [15:0] ref_model(input bit [7:0] a, b, input int kind,
                                            input int cols, input bit st2);
        bit [15:0] r [8];
        bit [15:0] s0, c0, s1, c1, s2, c2;
        for (int i = 0; i < 8; i++)
            r[i] = b[i] ? ({8'd0, a} << i) : 16'd0;
        ref_row(kind, cols, r[0], r[1], r[2], r[3], s0, c0);
        ref_row(kind, cols, r[4], r[5], r[6], r[7], s1, c1);
        ref_row(kind, st2 ? 16 : 0, s0, c0, s1, c1, s2, c2);
        return s2 + c2;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp, input int cfg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cfg=%0d actual=%h expected=%h", req, cfg, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] av, input logic [7:0] bv);
        item_t it;
        @(negedge clk);
        a_drv = av;
        b_drv = bv;
        it.a = av;
        it.b = bv;
        it.exp[0] = 16'(av * bv);
        for (int i = 0; i < 6; i++)
            it.exp[i+1] = ref_model(av, bv, cfg_var(i), cfg_cols(i), cfg_st2(i));
        q.push_back(it);
    endtask

    // Monitor / scoreboard
    initial begin
        wait (started);
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [15:0] got [NCFG];
                int truth;
                int d;
                it = q.pop_front();
                got[0] = p_dut;
                for (int i = 0; i < 6; i++) got[i+1] = p_apx[i];
                truth = int'(it.a) * int'(it.b);
                for (int c = 0; c < NCFG; c++) begin
                    if (c == 0)
                        check(got[c] === it.exp[c], "R1 R3 R9 exact product", got[c], it.exp[c], c);
                    else if (cfg_var(c-1) == 1)
                        check(got[c] === it.exp[c], "R2 R4 R6 variant-1 model", got[c], it.exp[c], c);
                    else
                        check(got[c] === it.exp[c], "R2 R5 R6 variant-2 model", got[c], it.exp[c], c);
                    if (it.a == 8'd0 || it.b == 8'd0)
                        check(got[c] === 16'd0, "R7 zero operand", got[c], 16'd0, c);
                    if (it.b == 8'd1)
                        check(got[c] === {8'd0, it.a}, "R8 unit multiplier", got[c], {8'd0, it.a}, c);
                    d = int'(got[c]) - truth;
                    if (d != 0) begin
                        err_cnt[c]++;
                        err_sum[c] += (d < 0) ? -d : d;
                    end
                end
            end
        end
    end

    // Driver
    initial begin
        for (int c = 0; c < NCFG; c++) begin
            err_cnt[c] = 0;
            err_sum[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state visible right after release
        check(p_dut === 16'd0, "R9 reset value", p_dut, 16'd0, 0);
        for (int i = 0; i < 6; i++)
            check(p_apx[i] === 16'd0, "R9 reset value", p_apx[i], 16'd0, i + 1);
        started = 1'b1;
        for (int av = 0; av < 256; av++)
            for (int bv = 0; bv < 256; bv++)
                drive(8'(av), 8'(bv));
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        for (int c = 1; c < NCFG; c++)
            $display("cfg %0d: error rate %0.4f, mean error distance %0.3f", c,
                     real'(err_cnt[c]) / 65536.0, real'(err_sum[c]) / 65536.0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired before the sweep completed");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule